// File: doc/BRIEF.md
# Edge-Latched Dual-Bank Static RAM

This block is a clocked, synthesizable model of a static RAM whose accesses are framed by an active-low enable. It holds two independent banks of 4-bit words. The banks share one address bus and nothing else. Each bank has its own enable, write strobe, data input, data output, output-enable flag and output-valid flag. Tying the two enables and the two strobes together gives an 8-bit-wide memory. Keeping them apart, with the data buses joined outside the block, gives a memory twice as deep and 4 bits wide. With `ADDR_W` = 13 each bank holds 8K words. The default is smaller so that the model elaborates quickly.

All enable and strobe edges are found by comparing each input with its value at the previous system clock edge. A falling enable starts a cycle and captures the shared address. The strobe level at that same edge decides the kind of cycle:
- **Early write:** the strobe is low. The data input is written straight away, and the output stays off for the whole cycle.
- **Read:** the strobe is high. The output turns on one clock later and is flagged valid one clock after that.

During a read, a falling strobe performs a read-modify-write. It writes the data input to the captured address once. The output keeps showing the word it read. A high enable always ends the cycle and silences the outputs.

Top module: `dual_bank_sram`

## Requirements
- R1: After reset, every bank has `oe` = 0, `valid` = 0 and its `dout` slice = 0.
- R2: The address is taken at the clock edge where a bank's `en_n` is first seen low. Address changes later in the same cycle do not change which word is read or written.
- R3: In a cycle where `wr_n` is high at the capture edge, `oe` goes to 1 at the next clock edge. `valid` goes to 1 one clock edge after `oe`. Both stay at 1 until `en_n` goes high.
- R4: In a cycle where `wr_n` is low at the capture edge, the data input present at that edge is written to the captured address. `oe` and `valid` stay 0 for the whole cycle, even if `wr_n` later rises.
- R5: While `oe` is 1, the bank's `dout` slice shows the word stored at the captured address when the read was made. While `oe` is 0, the slice is 0.
- R6: While a bank's `en_n` is 1, its `oe` and `valid` are 0 in that same clock period. The next cycle then needs a fresh falling edge of `en_n`.
- R7: In a read cycle, the first falling edge of `wr_n` writes that bank's data input to the captured address, and `dout` keeps the word read before the write. Any later `wr_n` or data-input change in the same cycle writes nothing.
- R8: Bank b uses bits [4b+3:4b] of `din` and `dout` and bit b of every control vector. Activity on one bank never changes the contents or outputs of another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all edges are detected on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | ADDR_W | Shared word address |
| en_n | input | NUM_BANKS | Active-low enable, one bit per bank |
| wr_n | input | NUM_BANKS | Active-low write strobe, one bit per bank |
| din | input | NUM_BANKS*DATA_W | Write data, one slice per bank |
| dout | output | NUM_BANKS*DATA_W | Read data, one slice per bank, 0 when the output is off |
| oe | output | NUM_BANKS | Output driven (1) or high-impedance (0), per bank |
| valid | output | NUM_BANKS | Read data on `dout` is valid, per bank |

## Verification
The assertions assume that each bank's enable stays high for at least one full clock between cycles, and that every input is stable across each rising clock edge. The bench meets both assumptions: it changes inputs only at the falling clock edge and always inserts an idle clock after raising an enable. The assertions also assume that the memory words a read touches were written earlier. The bench therefore fills every address it later uses with early writes before it issues any read or read-modify-write.

// File: rtl/dual_bank_sram_pkg.sv
package dual_bank_sram_pkg;

   // Phase of one bank's access cycle
   typedef enum logic [2:0] {
      PH_IDLE,    // enable high, nothing captured
      PH_WRITE,   // early write taken, output held off
      PH_OPEN,    // read captured, output turns on next clock
      PH_ON,      // output on, data settling
      PH_VALID    // output on and valid
   } bank_phase_t;

endpackage

// File: rtl/sram_bank_array.sv
module sram_bank_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   // Single port; a read and a write in the same clock return the old word
   always_ff @(posedge clk) begin
      if (we) store[addr] <= wdata;
      if (re) rdata <= store[addr];
   end
endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
   import dual_bank_sram_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              oe_o,
   output logic              valid_o
);
   bank_phase_t       phase;
   logic [ADDR_W-1:0] addr_q;
   logic              en_prev, wr_prev, rmw_q;
   logic              cyc_start, in_read, wr_fall, rmw_fire, oe_q;

   assign cyc_start = en_prev && !en_n && (phase == PH_IDLE);
   assign in_read   = (phase == PH_OPEN) || (phase == PH_ON) || (phase == PH_VALID);
   assign wr_fall   = wr_prev && !wr_n;
   assign rmw_fire  = !en_n && in_read && wr_fall && !rmw_q;
   assign oe_q      = (phase == PH_ON) || (phase == PH_VALID);

   assign mem_we    = (cyc_start && !wr_n) || rmw_fire;
   assign mem_re    = !en_n && (phase == PH_OPEN);
   assign mem_addr  = (phase == PH_IDLE) ? addr : addr_q;
   assign mem_wdata = din;
   assign oe_o      = oe_q && !en_n;
   assign valid_o   = (phase == PH_VALID) && !en_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         addr_q  <= '0;
         en_prev <= 1'b1;
         wr_prev <= 1'b1;
         rmw_q   <= 1'b0;
      end else begin
         en_prev <= en_n;
         wr_prev <= wr_n;
         if (en_n) begin
            phase <= PH_IDLE;
            rmw_q <= 1'b0;
         end else begin
            unique case (phase)
               PH_IDLE: if (cyc_start) begin
                  addr_q <= addr;
                  phase  <= wr_n ? PH_OPEN : PH_WRITE;
               end
               PH_OPEN:  phase <= PH_ON;
               PH_ON:    phase <= PH_VALID;
               default:  phase <= phase;
            endcase
            if (rmw_fire) rmw_q <= 1'b1;
         end
      end
   end

   // R2: captured address holds for the whole cycle
   a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) && ($past(phase) != PH_IDLE) |-> $stable(addr_q));

   // R3: valid only follows a clock in which the output was on
   a_r3_valid_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(oe_o));

   // R4: an early-write cycle never turns the output on
   a_r4_write_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WRITE) |=> !oe_q);

   // R6: a high enable returns the bank to idle at the next edge
   a_r6_enable_ends: assert property (@(posedge clk) disable iff (!rst_n)
      en_n |=> (phase == PH_IDLE) && !rmw_q);

   // R7: once the modify write is taken, nothing more is written this cycle
   a_r7_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
      rmw_q |-> !mem_we);
endmodule

// File: rtl/dual_bank_sram.sv
module dual_bank_sram #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 4,
   parameter int NUM_BANKS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [NUM_BANKS-1:0]          en_n,
   input  logic [NUM_BANKS-1:0]          wr_n,
   input  logic [NUM_BANKS*DATA_W-1:0]   din,
   output logic [NUM_BANKS*DATA_W-1:0]   dout,
   output logic [NUM_BANKS-1:0]          oe,
   output logic [NUM_BANKS-1:0]          valid
);
   localparam int BUS_W = NUM_BANKS * DATA_W;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("dual_bank_sram: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dual_bank_sram: DATA_W must be positive");
   end
   if (NUM_BANKS < 1 || BUS_W < DATA_W) begin : g_bad_banks
      $error("dual_bank_sram: NUM_BANKS must be positive");
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic              we, re;
      logic [ADDR_W-1:0] maddr;
      logic [DATA_W-1:0] wdata, rdata;

      sram_bank_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
         .clk       (clk),
         .rst_n     (rst_n),
         .en_n      (en_n[b]),
         .wr_n      (wr_n[b]),
         .addr      (addr),
         .din       (din[b*DATA_W +: DATA_W]),
         .mem_we    (we),
         .mem_re    (re),
         .mem_addr  (maddr),
         .mem_wdata (wdata),
         .oe_o      (oe[b]),
         .valid_o   (valid[b])
      );

      sram_bank_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
         .clk   (clk),
         .we    (we),
         .re    (re),
         .addr  (maddr),
         .wdata (wdata),
         .rdata (rdata)
      );

      // Output off reads as zero
      assign dout[b*DATA_W +: DATA_W] = oe[b] ? rdata : '0;

      // R5: an off output carries no data
      a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
         !oe[b] |-> (dout[b*DATA_W +: DATA_W] == '0));
   end
endmodule

// File: tb/dual_bank_sram_tb.sv
module dual_bank_sram_tb;
   localparam int AW = 11;
   localparam int DW = 4;
   localparam int NB = 2;
   localparam int NADDR = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic [NB-1:0]    en_n = '1;
   logic [NB-1:0]    wr_n = '1;
   logic [NB*DW-1:0] din  = '0;
   logic [NB*DW-1:0] dout;
   logic [NB-1:0]    oe, valid;

   int nvec = 0;
   int nfail = 0;

   always #5 clk = ~clk;

   dual_bank_sram #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(NB)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .en_n(en_n), .wr_n(wr_n),
      .din(din), .dout(dout), .oe(oe), .valid(valid)
   );

   // Behavioural reference: step counts since the capture edge
   int m_mem [NB][1<<AW];
   int m_step [NB];     // 0 idle, -1 early write, 1.. read steps (saturate at 3)
   int m_addr [NB];
   int m_rd [NB];
   bit m_done [NB];
   bit m_enp [NB];
   bit m_wrp [NB];

   always @(posedge clk) begin
      for (int b = 0; b < NB; b++) begin
         if (!rst_n) begin
            m_step[b] = 0; m_done[b] = 0; m_enp[b] = 1; m_wrp[b] = 1; m_rd[b] = 0;
         end else begin
            if (en_n[b]) begin
               m_step[b] = 0; m_done[b] = 0;
            end else if (m_step[b] == 0) begin
               if (m_enp[b]) begin
                  m_addr[b] = int'(addr);
                  if (!wr_n[b]) begin
                     m_mem[b][m_addr[b]] = int'(din[b*DW +: DW]);
                     m_step[b] = -1;
                  end else m_step[b] = 1;
               end
            end else if (m_step[b] > 0) begin
               if (m_step[b] == 1) m_rd[b] = m_mem[b][m_addr[b]];
               if (m_wrp[b] && !wr_n[b] && !m_done[b]) begin
                  m_mem[b][m_addr[b]] = int'(din[b*DW +: DW]);
                  m_done[b] = 1;
               end
               if (m_step[b] < 3) m_step[b] = m_step[b] + 1;
            end
            m_enp[b] = en_n[b];
            m_wrp[b] = wr_n[b];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // Advance one clock, then compare all outputs against the reference
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      for (int b = 0; b < NB; b++) begin
         logic eo, ev;
         eo = (m_step[b] >= 2) && !en_n[b];
         ev = (m_step[b] == 3) && !en_n[b];
         chk($sformatf("R3 oe bank%0d", b), 32'(oe[b]), 32'(eo));
         chk($sformatf("R3 valid bank%0d", b), 32'(valid[b]), 32'(ev));
         chk($sformatf("R5 dout bank%0d", b), 32'(dout[b*DW +: DW]),
             eo ? 32'(m_rd[b]) : 32'd0);
      end
   endtask

   task automatic early_write(input int b, input int a, input int d);
      addr = AW'(a); din[b*DW +: DW] = DW'(d); wr_n[b] = 1'b0; en_n[b] = 1'b0;
      step();
      // R2/R4: disturb address, data and strobe after capture
      addr = AW'(a ^ 5); din[b*DW +: DW] = DW'(~d); wr_n[b] = 1'b1;
      step();
      chk("R4 output off during early write", 32'(oe[b]), 32'd0);
      step();
      en_n[b] = 1'b1;
      #1 chk("R6 oe gated by high enable", 32'(oe[b] | valid[b]), 32'd0);
      step();
   endtask

   task automatic read_cyc(input int b, input int a, input int hold);
      addr = AW'(a); wr_n[b] = 1'b1; en_n[b] = 1'b0;
      step();
      addr = AW'(a + 7);
      step();
      step();
      chk("R2 word from captured address", 32'(dout[b*DW +: DW]), 32'(m_mem[b][a]));
      chk("R3 valid one clock after oe", 32'(valid[b]), 32'd1);
      for (int i = 0; i < hold; i++) step();
      en_n[b] = 1'b1;
      #1 chk("R6 valid gated by high enable", 32'(valid[b]), 32'd0);
      step();
   endtask

   task automatic rmw_cyc(input int b, input int a, input int d, input int wdelay);
      int old;
      old = m_mem[b][a];
      addr = AW'(a); wr_n[b] = 1'b1; en_n[b] = 1'b0;
      step();
      addr = AW'(a + 3);
      for (int i = 0; i < wdelay; i++) step();
      din[b*DW +: DW] = DW'(d); wr_n[b] = 1'b0;
      step();
      din[b*DW +: DW] = DW'(d ^ 9); wr_n[b] = 1'b1;
      step();
      wr_n[b] = 1'b0;
      step();
      step();
      if (wdelay >= 2)
         chk("R7 dout keeps word read before modify", 32'(dout[b*DW +: DW]), 32'(old));
      en_n[b] = 1'b1; wr_n[b] = 1'b1;
      step();
      chk("R7 modify wrote first strobe data only", 32'(m_mem[b][a]), 32'(d & 15));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 oe after reset", 32'(oe), 32'd0);
      chk("R1 valid after reset", 32'(valid), 32'd0);
      chk("R1 dout after reset", 32'(dout), 32'd0);
      rst_n = 1'b1;
      step();
      chk("R1 quiet after release", 32'(oe | valid), 32'd0);

      // Fill both banks with different patterns
      for (int b = 0; b < NB; b++)
         for (int a = 0; a < NADDR; a++)
            early_write(b, a, (a * 3 + b * 7 + 1) & 15);

      // R8: bank 1 contents untouched by bank 0 writes
      read_cyc(1, 4, 1);
      chk("R8 bank1 word after bank0 fill", 32'(m_mem[1][4]), 32'((4 * 3 + 7 + 1) & 15));
      read_cyc(0, 9, 0);
      read_cyc(0, NADDR - 1, 3);

      // Read-modify-write at different strobe delays
      rmw_cyc(0, 2, 4'hA, 2);
      rmw_cyc(1, 3, 4'h5, 0);
      rmw_cyc(0, 7, 4'hC, 3);
      read_cyc(0, 2, 0);
      read_cyc(1, 2, 0);

      // R8: simultaneous reads of the same address in both banks
      addr = AW'(6); wr_n = '1; en_n = '0;
      step(); step(); step();
      chk("R8 bank0 shared address", 32'(dout[3:0]), 32'(m_mem[0][6]));
      chk("R8 bank1 shared address", 32'(dout[7:4]), 32'(m_mem[1][6]));
      en_n = '1;
      step();

      // Strobe toggles while enable is high: no write, no output
      wr_n[0] = 1'b0; din[3:0] = 4'hF; step(); wr_n[0] = 1'b1; step();
      chk("R6 idle strobe wrote nothing", 32'(m_mem[0][6]), 32'((6 * 3 + 1) & 15));
      read_cyc(0, 6, 0);

      // Mixed sequence
      for (int i = 0; i < 300; i++) begin
         int b, a, k;
         b = $urandom_range(NB - 1);
         a = $urandom_range(NADDR - 1);
         k = $urandom_range(2);
         if (k == 0) early_write(b, a, $urandom_range(15));
         else if (k == 1) read_cyc(b, a, $urandom_range(2));
         else rmw_cyc(b, a, $urandom_range(15), $urandom_range(3));
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule